// File: doc/BRIEF.md
# Bidirectional GPIO Port with Halt Wake-up

This block is one 8-bit general-purpose I/O port of a small microcontroller. The CPU reaches it over a single-cycle bus through two addresses. One address holds the output data latch. The other holds the direction-control register. From these two registers the block drives each pad's output enable, output value and pull-up enable. When the CPU reads the data address, each bit comes from the output latch if that pin is an output, or from the live pad if that pin is an input.

Three pins are shared with other functions. Pin 5 feeds the external interrupt input and pin 4 feeds the external timer clock. Both take the pad level at all times, whatever the pin's direction. Pin 3 can carry the output of the frequency generator. This happens only when a static configuration bit selects that function and the pin's direction bit makes it an output.

While the core is halted, a falling edge on any pin whose wake-up select bit is set raises a wake-up request. A small state machine owns this request. It has three states:
- ST_RUN: the core is running.
- ST_HALT: the core is halted and the block watches for a selected falling edge.
- ST_WAKE: the request is raised.

It has four transitions:
- GO_HALT: ST_RUN to ST_HALT, taken when halt rises.
- GO_WAKE: ST_HALT to ST_WAKE, taken on a selected falling edge.
- QUIT_HALT: ST_HALT to ST_RUN, taken when halt drops with no edge seen.
- RELEASE: ST_WAKE to ST_RUN, taken when halt drops.

Top module: `pio_port`

## Requirements
- R1: After reset every direction bit is 1, every pin is an input with pad_oe low, and the output latch is 0.
- R2: Direction bit 1 makes the pin an input (pad_oe 0) and bit 0 makes it an output (pad_oe 1). A read at address 1 returns the direction register.
- R3: A read at address 0 returns the latch bit for each output pin and the current pad_in bit for each input pin.
- R4: The output latch changes only on a write to address 0, and such a write updates every bit, including bits of input pins. pad_out shows the latch on every pin except as stated in R6.
- R5: pad_pu is high for a pin only when its static pull option is set and the pin is an input.
- R6: Pin 3 drives pfd_in on pad_out when cfg_pfd is 1 and direction bit 3 is 0. Otherwise pad_out bit 3 is latch bit 3.
- R7: ext_int always equals pad_in bit 5 and tmr_clk always equals pad_in bit 4, whatever the pin directions.
- R8: While halted, a high-to-low change on a pin with cfg_wake set raises wake_req within four clock edges. wake_req stays high until halted drops, and is low one edge after that.
- R9: No wake-up request comes from a pin whose cfg_wake bit is 0, from a rising edge, or from a falling edge that happened before the halt began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | Register select: 0 data, 1 direction |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output values |
| pad_pu | output | 8 | Pad pull-up enables |
| cfg_pull | input | 8 | Static per-pin pull option |
| cfg_wake | input | 8 | Per-pin wake-up select |
| cfg_pfd | input | 1 | Static option routing the frequency output to pin 3 |
| pfd_in | input | 1 | Frequency generator output |
| halted | input | 1 | Core is in the halt state |
| wake_req | output | 1 | Wake-up request |
| ext_int | output | 1 | Pin 5 level to the interrupt logic |
| tmr_clk | output | 1 | Pin 4 level to the timer |

## Verification
Some properties are checked on every cycle. The output latch stays stable when there is no data write. Pull-up is never enabled on a pin that drives its pad. The wake-up request never rises outside a halt, stays held while the halt lasts, and clears right after the halt ends. The bench sweeps all 256 direction values, with varied latch, pad and pin-3 settings, and compares read data and every pad signal against values it computes itself. Only the bench scenarios can show that each single pin wakes the device, and that rising edges, deselected pins and edges before the halt do not.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_WAKE = 2'd2
    } wake_state_t;
endpackage

// File: rtl/pio_regs.sv
module pio_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_addr,
    input  logic         bus_we,
    input  logic [W-1:0] bus_wdata,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] bus_rdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] latch_q
);
    import pio_pkg::*;

    logic wr_data, wr_ctrl;

    assign wr_data = bus_we && (bus_addr == ADDR_DATA);
    assign wr_ctrl = bus_we && (bus_addr == ADDR_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '1;
            latch_q <= '0;
        end else begin
            if (wr_ctrl) dir_q   <= bus_wdata;
            if (wr_data) latch_q <= bus_wdata;
        end
    end

    always_comb begin
        if (bus_addr == ADDR_CTRL) bus_rdata = dir_q;
        else                       bus_rdata = (dir_q & pad_in) | (~dir_q & latch_q);
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data |=> $stable(latch_q)); // R4

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(dir_q)); // R2
endmodule

// File: rtl/pio_padmux.sv
module pio_padmux #(
    parameter int W       = 8,
    parameter int PFD_PIN = 3
) (
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] cfg_pull,
    input  logic         cfg_pfd,
    input  logic         pfd_in,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        assign pad_oe[i] = ~dir_q[i];
        assign pad_pu[i] = cfg_pull[i] & dir_q[i];
        if (i == PFD_PIN) begin : g_pfd
            assign pad_out[i] = (cfg_pfd && !dir_q[i]) ? pfd_in : latch_q[i];
        end else begin : g_plain
            assign pad_out[i] = latch_q[i];
        end
    end
endmodule

// File: rtl/pio_wake.sv
module pio_wake #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] cfg_wake,
    input  logic         halted,
    output logic         wake_req
);
    import pio_pkg::*;

    wake_state_t state, state_nx;
    logic [W-1:0] sync1, sync2, prev;
    logic         fall_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= '1;
            sync2 <= '1;
            prev  <= '1;
        end else begin
            sync1 <= pad_in;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    assign fall_any = |(prev & ~sync2 & cfg_wake);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (halted) state_nx = ST_HALT;
            ST_HALT: if (!halted) state_nx = ST_RUN;
                     else if (fall_any) state_nx = ST_WAKE;
            ST_WAKE: if (!halted) state_nx = ST_RUN;
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        wake_req = (state == ST_WAKE);
    end

    AST_WAKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && halted) |=> wake_req); // R8

    AST_WAKE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !halted) |=> !wake_req); // R8

    AST_WAKE_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> $past(halted)); // R9
endmodule

// File: rtl/pio_port.sv
module pio_port #(
    parameter int W       = 8,
    parameter int PFD_PIN = 3,
    parameter int TMR_PIN = 4,
    parameter int INT_PIN = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_addr,
    input  logic         bus_we,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu,
    input  logic [W-1:0] cfg_pull,
    input  logic [W-1:0] cfg_wake,
    input  logic         cfg_pfd,
    input  logic         pfd_in,
    input  logic         halted,
    output logic         wake_req,
    output logic         ext_int,
    output logic         tmr_clk
);
    logic [W-1:0] dir_q, latch_q;

    pio_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .pad_in(pad_in), .bus_rdata(bus_rdata),
        .dir_q(dir_q), .latch_q(latch_q)
    );

    pio_padmux #(.W(W), .PFD_PIN(PFD_PIN)) u_mux (
        .dir_q(dir_q), .latch_q(latch_q), .cfg_pull(cfg_pull),
        .cfg_pfd(cfg_pfd), .pfd_in(pfd_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    pio_wake #(.W(W)) u_wake (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .cfg_wake(cfg_wake),
        .halted(halted), .wake_req(wake_req)
    );

    assign ext_int = pad_in[INT_PIN];
    assign tmr_clk = pad_in[TMR_PIN];

    AST_PULL_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0); // R5
endmodule

// File: tb/sim_pio_port.sv
module sim_pio_port;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 0, rst_n = 0;
    logic         bus_addr = 0, bus_we = 0;
    logic [W-1:0] bus_wdata = 0, bus_rdata;
    logic [W-1:0] pad_in = '1, pad_oe, pad_out, pad_pu;
    logic [W-1:0] cfg_pull = 8'hC3, cfg_wake = 0;
    logic         cfg_pfd = 0, pfd_in = 0, halted = 0;
    logic         wake_req, ext_int, tmr_clk;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
        .cfg_pull(cfg_pull), .cfg_wake(cfg_wake), .cfg_pfd(cfg_pfd),
        .pfd_in(pfd_in), .halted(halted), .wake_req(wake_req),
        .ext_int(ext_int), .tmr_clk(tmr_clk)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] lat, pad, exp_out, exp_rd;
        cycles(2);
        rst_n = 1;
        cycles(1);
        // R1 reset state
        chk("R1 oe", pad_oe, 8'h00);
        bus_addr = 1; #1;
        chk("R1 dir", bus_rdata, 8'hFF);
        bus_write(1, 8'h00);
        bus_addr = 0; #1;
        chk("R1 latch", bus_rdata, 8'h00);
        chk("R1 pad_out", pad_out, 8'h00);

        // Sweep every direction value
        for (int c = 0; c < 256; c++) begin
            lat = 8'(c) ^ 8'h5A;
            pad = ~8'(c) ^ 8'h33;
            bus_write(1, 8'(c));
            bus_write(0, lat);
            pad_in = pad; cfg_pfd = c[7]; pfd_in = c[6];
            bus_addr = 1; #1;
            chk("R2 dir read", bus_rdata, 8'(c));
            chk("R2 oe", pad_oe, ~8'(c));
            bus_addr = 0; #1;
            exp_rd = (8'(c) & pad) | (~8'(c) & lat);
            chk("R3 data read", bus_rdata, exp_rd);
            chk("R5 pull", pad_pu, 8'hC3 & 8'(c));
            exp_out = lat;
            if (c[7] && !c[3]) exp_out[3] = c[6];
            chk("R6 R4 pad_out", pad_out, exp_out);
            chk("R7 int tmr", {6'b0, ext_int, tmr_clk}, {6'b0, pad[5], pad[4]});
        end

        // R4: latch holds across direction writes and input changes
        bus_write(0, 8'hA5);
        bus_write(1, 8'hFF);
        pad_in = 8'h0F;
        cycles(3);
        bus_write(1, 8'h00);
        bus_addr = 0; #1;
        chk("R4 latch hold", bus_rdata, 8'hA5);
        bus_write(1, 8'hFF);
        pad_in = '1;
        cycles(5);

        // R8 / R9 per-pin wake
        for (int i = 0; i < W; i++) begin
            cfg_wake = 8'(1 << i);
            halted = 1; cycles(2);
            pad_in[i] = 0;
            cycles(4);
            chk("R8 wake", {7'b0, wake_req}, 8'd1);
            cycles(3);
            chk("R8 held", {7'b0, wake_req}, 8'd1);
            halted = 0; cycles(1);
            chk("R8 release", {7'b0, wake_req}, 8'd0);
            pad_in = '1; cycles(5);

            // unselected pin
            cfg_wake = ~8'(1 << i);
            halted = 1; cycles(2);
            pad_in[i] = 0; cycles(6);
            chk("R9 unselected", {7'b0, wake_req}, 8'd0);
            // rising edge on the pin
            pad_in[i] = 1; cycles(6);
            chk("R9 rising", {7'b0, wake_req}, 8'd0);
            halted = 0; cycles(2);

            // falling before halt
            cfg_wake = '1;
            pad_in[i] = 0; cycles(6);
            halted = 1; cycles(6);
            chk("R9 early fall", {7'b0, wake_req}, 8'd0);
            halted = 0; pad_in = '1; cycles(5);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule